// File: doc/BRIEF.md
# Flag-Pin Serial Display Command Engine

This block talks to a small display controller over a four-wire serial link (clock, data out, data in, chip select) plus a separate pin that tells the controller whether the byte on the wire is a command or a parameter. A requester hands over one transaction at a time: an opcode and a byte count. The engine looks up the opcode in a fixed table of read opcodes to decide whether it is a write or a read.

For a write, the engine shifts the opcode and then the parameter bytes. It takes those bytes from a valid/ready input stream, one byte at a time. When the engine does not need a byte, `wr_ready` stays low, and the serial clock pauses while the stream is empty.

For a read, the engine shifts the opcode and then clocks in the requested number of bytes at a slower read clock. It hands those bytes out on a valid/ready output stream. A held output byte stays stable until `rd_ready` is seen. The engine starts no new read byte while the output slot is full, so back-pressure stalls the serial clock instead of losing data.

Two identification opcodes return data that is one bit late on the wire. For these, the engine clocks one extra byte and shifts the result back into alignment. The engine refuses a read with an illegal length and raises an error pulse instead.

Top module: `lcd_cmd_spi_engine`

## Requirements
- R1: Chip select is low for the whole transaction and high between transactions. The flag pin is low while the opcode byte is shifted and high for every later byte of the same transaction.
- R2: A write whose byte count is 0 ends after the 8 clocks of the opcode byte: exactly one byte is framed.
- R3: Write parameter bytes are shifted most significant bit first, in the order they are accepted. Each clock level lasts WR_HALF system cycles (default 2 cycles, so 12.5 MHz from 50 MHz).
- R4: The read opcodes are 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A to 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8. Any other opcode is a write. During a read, both the opcode and the returned bytes run at a clock level of max(ceil(CLK_HZ/(2*RD_MAX_HZ)), 2*WR_HALF) cycles (13 cycles by default, under 2 MHz). The data-out pin is 0 during the returned bytes.
- R5: A read with a byte count of 0 is rejected. `err` pulses for one cycle in the cycle after acceptance, and no frame is started.
- R6: Opcodes 0x04 and 0x09 accept only byte counts 3 and 4, and any other count is rejected as in R5. For an accepted count N, N+1 bytes are clocked in after the opcode.
- R7: For 0x04 and 0x09, the output byte i equals ((raw byte i) << 1, truncated to 8 bits) OR bit 7 of raw byte i+1. For all other reads, the output bytes equal the raw bytes.
- R8: For opcode 0x2C with `swap` low, parameter bytes go out in pairs, with the second byte of each pair first. A lone final byte goes out alone. With `swap` high, they go out in arrival order. `swap` is sampled when the request is accepted.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. No read byte is lost under back-pressure.
- R10: `req_ready` is high only when the engine is idle. `wr_ready` is high only while the engine waits for a parameter byte.
- R11: The serial clock idles low. Data out changes only while the clock is low, and data in is sampled on the rising edge.
- R12: After reset: chip select high, clock low, flag low, `req_ready` high, `rd_valid` low, `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swap | input | 1 | Byte-swap mode for 0x2C parameters |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken |
| req_op | input | 8 | Opcode |
| req_len | input | LEN_W | Parameter or result byte count |
| wr_valid | input | 1 | Parameter byte offered |
| wr_ready | output | 1 | Engine takes a parameter byte |
| wr_data | input | 8 | Parameter byte |
| rd_valid | output | 1 | Result byte available |
| rd_ready | input | 1 | Consumer takes the result byte |
| rd_data | output | 8 | Result byte |
| err | output | 1 | One-cycle pulse: illegal read length |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dc | output | 1 | Command (0) / parameter (1) flag |

## Verification
The assertions check these behaviours on every cycle:
- the clock stays low outside a frame;
- the flag is low when a frame opens;
- a rejected request never opens a frame;
- the held output byte stays stable under back-pressure;
- data out moves only while the clock is low.

Only the bench scenarios can show the following, by rebuilding the bytes seen on the pins and comparing them with a behavioural model:
- the byte order of the 0x2C pair swap;
- the one-bit realignment of the identification reads;
- the exact clock half-period of writes and reads;
- the acceptance rules for read byte counts.

// File: rtl/lcd_eng_pkg.sv
package lcd_eng_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WGET, S_WSHIFT, S_RSTART, S_RSHIFT, S_END
  } eng_state_t;

  localparam logic [7:0] OP_IDENT  = 8'h04;
  localparam logic [7:0] OP_STATUS = 8'h09;
  localparam logic [7:0] OP_MEMWR  = 8'h2C;

  function automatic logic op_is_read(input logic [7:0] op);
    case (op)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09,
      8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F,
      8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56,
      8'h5F, 8'hA1, 8'hA8: op_is_read = 1'b1;
      default:             op_is_read = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lcd_op_decode.sv
module lcd_op_decode
  import lcd_eng_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [7:0]       op,
  input  logic [LEN_W-1:0] len,
  input  logic             swap,
  output logic             is_read,
  output logic             realign,
  output logic             bad_len,
  output logic             pair_swap
);
  logic len_ok;

  assign is_read = op_is_read(op);
  assign realign = (op == OP_IDENT) || (op == OP_STATUS);

  always_comb begin
    if (realign) len_ok = (len == LEN_W'(3)) || (len == LEN_W'(4));
    else         len_ok = (len != '0);
  end

  assign bad_len   = is_read && !len_ok;
  assign pair_swap = !is_read && (op == OP_MEMWR) && !swap;
endmodule

// File: rtl/lcd_bit_shifter.sv
module lcd_bit_shifter #(
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HALF_W-1:0] half,
  input  logic [7:0]        tx,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [7:0]        rx
);
  logic [HALF_W-1:0] cnt, half_q;
  logic [7:0]        sh;
  logic [2:0]        bitn;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; half_q <= '0; sh <= '0; bitn <= '0;
      busy <= 1'b0; sclk <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        sh     <= tx;
        bitn   <= '0;
        cnt    <= half - 1'b1;
        half_q <= half;
        sclk   <= 1'b0;
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= half_q - 1'b1;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign mosi = sh[7];

  // R11: data out only moves while the clock is low
  assert_mosi_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$stable(mosi) |-> !sclk);
endmodule

// File: rtl/lcd_realign.sv
module lcd_realign (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);
  logic [7:0] prev;
  logic       have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      have <= 1'b0;
    end else if (clr) begin
      have <= 1'b0;
    end else if (in_valid) begin
      prev <= in_byte;
      have <= 1'b1;
    end
  end

  assign out_valid = in_valid && (!en || have);
  assign out_byte  = en ? {prev[6:0], in_byte[7]} : in_byte;
endmodule

// File: rtl/lcd_cmd_spi_engine.sv
module lcd_cmd_spi_engine
  import lcd_eng_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int RD_MAX_HZ = 2_000_000,
  parameter int WR_HALF   = 2,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_op,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             err,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n,
  output logic             spi_dc
);
  localparam int RD_HALF_CAP = (CLK_HZ + 2 * RD_MAX_HZ - 1) / (2 * RD_MAX_HZ);
  localparam int RD_HALF     = (RD_HALF_CAP > 2 * WR_HALF) ? RD_HALF_CAP : 2 * WR_HALF;
  localparam int HALF_W      = $clog2(RD_HALF + 1);
  localparam int REM_W       = LEN_W + 1;

  eng_state_t        state;
  logic [REM_W-1:0]  rem;
  logic              is_rd_q, rl_en_q, pair_q, have_hold;
  logic [7:0]        hold, sh_tx, out_q;
  logic [HALF_W-1:0] half_q;
  logic              sh_start, out_v, err_q, cs_q, dc_q;

  logic dec_read, dec_realign, dec_bad, dec_pair;
  logic sh_done;
  logic [7:0] sh_rx;
  logic rl_clr, rl_in_valid, rl_valid;
  logic [7:0] rl_byte;
  logic wr_fire;

  lcd_op_decode #(.LEN_W(LEN_W)) u_dec (
    .op(req_op), .len(req_len), .swap(swap),
    .is_read(dec_read), .realign(dec_realign),
    .bad_len(dec_bad), .pair_swap(dec_pair)
  );

  lcd_bit_shifter #(.HALF_W(HALF_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .half(half_q),
    .tx(sh_tx), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .done(sh_done), .rx(sh_rx)
  );

  assign rl_clr      = (state == S_IDLE) && req_valid && !dec_bad;
  assign rl_in_valid = (state == S_RSHIFT) && sh_done;

  lcd_realign u_align (
    .clk(clk), .rst_n(rst_n), .clr(rl_clr), .en(rl_en_q),
    .in_valid(rl_in_valid), .in_byte(sh_rx),
    .out_valid(rl_valid), .out_byte(rl_byte)
  );

  assign req_ready = (state == S_IDLE);
  assign wr_ready  = (state == S_WGET);
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_valid  = out_v;
  assign rd_data   = out_q;
  assign err       = err_q;
  assign spi_cs_n  = cs_q;
  assign spi_dc    = dc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; rem <= '0; is_rd_q <= 1'b0; rl_en_q <= 1'b0;
      pair_q <= 1'b0; have_hold <= 1'b0; hold <= '0; sh_tx <= '0;
      out_q <= '0; half_q <= '0; sh_start <= 1'b0; out_v <= 1'b0;
      err_q <= 1'b0; cs_q <= 1'b1; dc_q <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      err_q    <= 1'b0;
      if (rd_valid && rd_ready) out_v <= 1'b0;
      if (rl_valid) begin
        out_q <= rl_byte;
        out_v <= 1'b1;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          if (dec_bad) begin
            err_q <= 1'b1;
          end else begin
            cs_q      <= 1'b0;
            dc_q      <= 1'b0;
            sh_tx     <= req_op;
            sh_start  <= 1'b1;
            is_rd_q   <= dec_read;
            rl_en_q   <= dec_realign;
            pair_q    <= dec_pair;
            have_hold <= 1'b0;
            rem       <= dec_realign ? {1'b0, req_len} + 1'b1 : {1'b0, req_len};
            half_q    <= dec_read ? HALF_W'(RD_HALF) : HALF_W'(WR_HALF);
            state     <= S_CMD;
          end
        end
        S_CMD: if (sh_done) begin
          if (rem == '0) begin
            state <= S_END;
          end else begin
            dc_q  <= 1'b1;
            state <= is_rd_q ? S_RSTART : S_WGET;
          end
        end
        S_WGET: if (wr_fire) begin
          rem <= rem - 1'b1;
          if (pair_q && !have_hold && rem >= REM_W'(2)) begin
            hold      <= wr_data;
            have_hold <= 1'b1;
          end else begin
            sh_tx    <= wr_data;
            sh_start <= 1'b1;
            state    <= S_WSHIFT;
          end
        end
        S_WSHIFT: if (sh_done) begin
          if (have_hold) begin
            sh_tx     <= hold;
            sh_start  <= 1'b1;
            have_hold <= 1'b0;
          end else if (rem == '0) begin
            state <= S_END;
          end else begin
            state <= S_WGET;
          end
        end
        S_RSTART: if (!out_v) begin
          sh_tx    <= 8'h00;
          sh_start <= 1'b1;
          state    <= S_RSHIFT;
        end
        S_RSHIFT: if (sh_done) begin
          rem   <= rem - 1'b1;
          state <= (rem == REM_W'(1)) ? S_END : S_RSTART;
        end
        S_END: begin
          cs_q  <= 1'b1;
          dc_q  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: clock rests low outside a frame
  assert_clock_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R1: a frame always opens in command phase
  assert_frame_opens_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_dc);
  // R5: a rejected request opens no frame
  assert_reject_no_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> spi_cs_n);
  // R9: held result byte stays put under back-pressure
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
endmodule

// File: tb/lcd_cmd_spi_engine_bench.sv
module lcd_cmd_spi_engine_bench;
  localparam int HALF_WR = 2;
  localparam int HALF_RD = 13;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, swap, req_valid, req_ready, wr_valid, wr_ready;
  logic rd_valid, rd_ready, err, spi_sclk, spi_mosi, spi_miso, spi_cs_n, spi_dc;
  logic [7:0] req_op, wr_data, rd_data;
  logic [7:0] req_len;

  lcd_cmd_spi_engine u_lcd_cmd_spi_engine (
    .clk(clk), .rst_n(rst_n), .swap(swap),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .err(err),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- pin-level model: frames, bytes, clock timing, slave responses ----
  logic [8:0] got_q[$];
  logic [7:0] resp_q[$];
  int  rises = 0, run = 0, minhigh = 1000, frames = 0, idle_bad = 0;
  logic [7:0] shin = '0;
  logic sclk_p = 1'b0, cs_p = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n && spi_sclk) idle_bad++;
      if (cs_p && !spi_cs_n) begin
        frames++; rises = 0; run = 0; minhigh = 1000;
      end
      if (!spi_cs_n) begin
        if (spi_sclk !== sclk_p) begin
          if (!spi_sclk && run < minhigh) minhigh = run;
          run = 1;
        end else run++;
        if (spi_sclk && !sclk_p) begin
          shin = {shin[6:0], spi_mosi};
          if (rises % 8 == 7) got_q.push_back({spi_dc, shin});
          rises++;
        end
      end
      begin
        int bi;
        bi = rises - 8;
        if (bi >= 0 && (bi / 8) < resp_q.size()) spi_miso = resp_q[bi / 8][7 - (bi % 8)];
        else spi_miso = 1'b0;
      end
    end
    sclk_p = spi_sclk;
    cs_p   = spi_cs_n;
  end

  // ---- parameter feeder with gaps, result collector with back-pressure ----
  logic [7:0] wr_q[$];
  logic [7:0] rd_got[$];
  bit wr_fire_p = 0;
  int cyc = 0;
  int bp_mode = 0;

  always @(negedge clk) begin
    cyc++;
    if (wr_fire_p) void'(wr_q.pop_front());
    wr_valid = (wr_q.size() != 0) && (cyc % 3 != 0);
    wr_data  = (wr_q.size() != 0) ? wr_q[0] : 8'h00;
    wr_fire_p = wr_valid && wr_ready;
    rd_ready = (bp_mode == 0) ? 1'b1 : (cyc % 97 == 0);
    if (rd_valid && rd_ready) rd_got.push_back(rd_data);
  end

  task automatic issue(input logic [7:0] op, input int len, output logic e);
    @(negedge clk);
    req_op = op; req_len = 8'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e = err;
  endtask

  task automatic finish_frame();
    int guard;
    guard = 0;
    while (!spi_cs_n && guard < 20000) begin @(negedge clk); guard++; end
    repeat (300) @(negedge clk);
  endtask

  // write transaction: expected wire bytes come from R1/R3/R8
  task automatic do_write(input logic [7:0] op, input logic [7:0] p[$], input logic sw, input string tag);
    logic [8:0] exp[$];
    logic e;
    int f0;
    swap = sw; got_q.delete(); resp_q.delete(); f0 = frames;
    exp.push_back({1'b0, op});
    for (int i = 0; i < p.size(); i++) begin
      if (op == 8'h2C && !sw && (i % 2 == 0) && (i + 1 < p.size())) begin
        exp.push_back({1'b1, p[i + 1]});
        exp.push_back({1'b1, p[i]});
        i++;
      end else exp.push_back({1'b1, p[i]});
    end
    foreach (p[i]) wr_q.push_back(p[i]);
    issue(op, p.size(), e);
    finish_frame();
    check({tag, " R5 no error on write"}, e, 1'b0);
    check({tag, " R1 one frame"}, frames - f0, 1);
    check({tag, " R2 byte count"}, got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++)
      check({tag, " R1/R3/R8 wire byte {flag,data}"}, got_q[i], exp[i]);
    check({tag, " R3 write half period"}, minhigh, HALF_WR);
  endtask

  // read transaction: expected outputs come from R4/R6/R7
  task automatic do_read(input logic [7:0] op, input int len, input logic [7:0] raw[$], input int bp, input string tag);
    logic [7:0] exp[$];
    logic e;
    int f0, nraw, guard;
    bit shifted;
    got_q.delete(); rd_got.delete(); resp_q = raw; f0 = frames; bp_mode = bp;
    shifted = (op == 8'h04 || op == 8'h09);
    nraw = shifted ? len + 1 : len;
    for (int i = 0; i < len; i++)
      exp.push_back(shifted ? 8'((raw[i] << 1) | (raw[i + 1] >> 7)) : raw[i]);
    issue(op, len, e);
    finish_frame();
    bp_mode = 0;
    guard = 0;
    while (rd_got.size() < len && guard < 500) begin @(negedge clk); guard++; end
    check({tag, " R5 no error on legal read"}, e, 1'b0);
    check({tag, " R1 one frame"}, frames - f0, 1);
    check({tag, " R6 bytes clocked"}, got_q.size(), nraw + 1);
    if (got_q.size() > 0) check({tag, " R1 opcode byte flag low"}, got_q[0], {1'b0, op});
    for (int i = 1; i < got_q.size(); i++)
      check({tag, " R4 read byte flag high, data out zero"}, got_q[i], 9'h100);
    check({tag, " R4 read half period"}, minhigh, HALF_RD);
    check({tag, " R9 result count"}, rd_got.size(), len);
    for (int i = 0; i < len && i < rd_got.size(); i++)
      check({tag, " R7 result byte"}, rd_got[i], exp[i]);
  endtask

  task automatic do_reject(input logic [7:0] op, input int len, input string tag);
    logic e;
    int f0;
    f0 = frames;
    issue(op, len, e);
    repeat (50) @(negedge clk);
    check({tag, " R5/R6 error pulse"}, e, 1'b1);
    check({tag, " R5/R6 no frame"}, frames - f0, 0);
    check({tag, " R5 error is one cycle"}, err, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; swap = 1'b0; req_valid = 1'b0; req_op = '0; req_len = '0;
    spi_miso = 1'b0; wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 cs high", spi_cs_n, 1'b1);
    check("R12 clock low", spi_sclk, 1'b0);
    check("R12 flag low", spi_dc, 1'b0);
    check("R12 rd_valid low", rd_valid, 1'b0);
    check("R12 err low", err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 R10 req_ready high", req_ready, 1'b1);
    check("R10 wr_ready low when idle", wr_ready, 1'b0);

    do_write(8'h2A, '{8'h00, 8'h01, 8'h00, 8'h7F}, 1'b0, "colwin");
    do_write(8'h29, '{}, 1'b0, "noparam R2");
    do_write(8'h2C, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 1'b0, "memwr pair R8");
    do_write(8'h2C, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, 1'b1, "memwr swapped R8");
    do_write(8'h36, '{8'hC8}, 1'b0, "single");

    do_read(8'h0A, 1, '{8'h9C}, 0, "powermode R4");
    do_read(8'h04, 3, '{8'h81, 8'h02, 8'h03, 8'h80}, 0, "ident3 R7");
    do_read(8'h09, 4, '{8'hFF, 8'h55, 8'hAA, 8'h01, 8'hC0}, 1, "status4 bp R9");
    do_read(8'h3E, 3, '{8'h12, 8'h34, 8'h56}, 1, "memrd bp R9");

    do_reject(8'h0A, 0, "zero len R5");
    do_reject(8'h04, 2, "ident len2 R6");
    do_reject(8'h09, 5, "status len5 R6");
    do_reject(8'h04, 0, "ident len0 R6");

    check("R11 clock low whenever cs high", idle_bad, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule